// File: doc/BRIEF.md
# Fault Escalator

This block sits between the sources that raise exceptions and the logic that dispatches them. Each cycle it may receive one raised vector with an optional error-code word. It classifies the vector as benign, contributory, page fault, double fault or reserved, and decides whether an error code goes with it. It also keeps track of the class of the event whose dispatch is still running. A second fault that arrives during that dispatch is either passed on unchanged, turned into a double fault (vector 8), or stops the core through a sticky shutdown flag.

The block also produces the coprocessor-not-available trap itself. When a coprocessor opcode strobe arrives while the task-switched flag is high, vector 7 is raised. The dispatch logic pulses the done strobe when a delivery has finished, and this marks the tracker idle again. Each result appears on registered outputs one clock after the input that causes it.

Top module: `fault_escalator`

## Requirements
- R1: With no delivery in progress, an accepted vector appears unchanged on `out_vector` with `out_valid` high one cycle later. In every cycle with no result, `out_valid`, `out_vector`, `out_has_code` and `out_code` are all zero.
- R2: The error-code outputs follow the vector. Vectors 0Ah–0Eh set `out_has_code` and pass `exc_code` through. Vectors 08h and 11h set `out_has_code` with a code of zero. All other vectors, including 09h, clear `out_has_code` and give a code of zero.
- R3: A contributory vector (00h, 09h–0Dh) raised while a contributory event is in delivery is issued as vector 08h with `out_has_code`=1 and code zero.
- R4: A contributory vector or a page fault (0Eh) raised while a page fault is in delivery is issued as vector 08h with `out_has_code`=1 and code zero.
- R5: A contributory vector or a page fault raised while a double fault is in delivery produces no output. `shutdown` rises one cycle later and stays high until reset, and while it is high no further result is issued.
- R6: Benign vectors (01h–07h, 10h, 11h, 12h) are never escalated. A page fault raised during a contributory delivery is issued unchanged.
- R7: Vectors 20h–FFh are issued unchanged with no error code, whatever is in delivery, and they never cause shutdown.
- R8: `fpu_op` together with `task_sw` raises vector 07h with no error code. `fpu_op` without `task_sw` raises nothing. When `exc_valid` is high in the same cycle, the explicit vector wins.
- R9: `dlv_done` returns the tracker to idle, but only in a cycle with no accepted event. In a cycle with an accepted event, the done strobe is ignored.
- R10: Reserved vectors 0Fh and 13h–1Fh produce no output and leave the in-delivery state unchanged.
- R11: After reset, `out_valid`, `shutdown` and all result outputs are zero and no delivery is in progress.
- R12: Vector 08h raised directly is issued as 08h with a code of zero, and it becomes the double fault in delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | A vector is raised this cycle |
| exc_vector | input | 8 | Raised vector number |
| exc_code | input | 16 | Error-code word supplied with the raised vector |
| dlv_done | input | 1 | Delivery of the current event has finished |
| task_sw | input | 1 | Task-switched flag |
| fpu_op | input | 1 | A coprocessor opcode was decoded this cycle |
| out_valid | output | 1 | A result is issued this cycle |
| out_vector | output | 8 | Final vector after escalation |
| out_has_code | output | 1 | The final vector pushes an error code |
| out_code | output | 16 | Error-code value to push |
| shutdown | output | 1 | Sticky shutdown indication |

## Verification
Every result is due exactly one clock after the cycle in which its inputs are presented. This holds for escalation to 08h, the coprocessor trap and the rise of `shutdown` alike, because one register stage lies between the inputs and each output. The bench drives inputs on the falling edge and compares all five outputs on the next falling edge, so each comparison looks at the single rising edge between those two points. Effects that depend on the in-delivery state are checked through a later vector's result, such as a contributory vector escalating or not after a reserved vector or a done strobe.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;

  typedef enum logic [2:0] {
    CLS_IDLE    = 3'd0,
    CLS_BENIGN  = 3'd1,
    CLS_CONTRIB = 3'd2,
    CLS_PAGE    = 3'd3,
    CLS_DOUBLE  = 3'd4
  } exc_class_t;

  localparam int VEC_DOUBLE   = 8;
  localparam int VEC_NO_FPU   = 7;
  localparam int VEC_PAGE     = 14;
  localparam int VEC_ALIGN    = 17;
  localparam int VEC_MCHK     = 18;
  localparam int VEC_FPU_ERR  = 16;

endpackage

// File: rtl/fault_esc_src.sv
module fault_esc_src #(
  parameter int VEC_W = 8,
  parameter int ERR_W = 16
) (
  input  logic             exc_valid,
  input  logic [VEC_W-1:0] exc_vector,
  input  logic [ERR_W-1:0] exc_code,
  input  logic             task_sw,
  input  logic             fpu_op,
  output logic             src_valid,
  output logic [VEC_W-1:0] src_vector,
  output logic [ERR_W-1:0] src_code
);
  import fault_esc_pkg::*;

  logic fpu_trap;

  assign fpu_trap = fpu_op && task_sw;

  always_comb begin
    src_valid  = exc_valid || fpu_trap;
    src_vector = '0;
    src_code   = '0;
    if (exc_valid) begin
      src_vector = exc_vector;
      src_code   = exc_code;
    end else if (fpu_trap) begin
      src_vector = VEC_W'(VEC_NO_FPU);
    end
  end

endmodule

// File: rtl/fault_esc_classify.sv
module fault_esc_classify #(
  parameter int VEC_W    = 8,
  parameter int IRQ_BASE = 32
) (
  input  logic                        vec_in,
  input  logic [VEC_W-1:0]            vector,
  output fault_esc_pkg::exc_class_t   cls,
  output logic                        pushes_code,
  output logic                        code_is_zero,
  output logic                        reserved
);
  import fault_esc_pkg::*;

  always_comb begin
    cls          = CLS_BENIGN;
    pushes_code  = 1'b0;
    code_is_zero = 1'b0;
    reserved     = 1'b0;
    if (int'(vector) >= IRQ_BASE) begin
      cls = CLS_BENIGN;
    end else begin
      case (int'(vector))
        0, 9:                cls = CLS_CONTRIB;
        10, 11, 12, 13: begin
          cls         = CLS_CONTRIB;
          pushes_code = 1'b1;
        end
        VEC_PAGE: begin
          cls         = CLS_PAGE;
          pushes_code = 1'b1;
        end
        VEC_DOUBLE: begin
          cls          = CLS_DOUBLE;
          pushes_code  = 1'b1;
          code_is_zero = 1'b1;
        end
        VEC_ALIGN: begin
          cls          = CLS_BENIGN;
          pushes_code  = 1'b1;
          code_is_zero = 1'b1;
        end
        1, 2, 3, 4, 5, 6, VEC_NO_FPU, VEC_FPU_ERR, VEC_MCHK:
                             cls = CLS_BENIGN;
        default:             reserved = vec_in;
      endcase
    end
  end

endmodule

// File: rtl/fault_esc_track.sv
module fault_esc_track #(
  parameter int VEC_W = 8,
  parameter int ERR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      src_valid,
  input  logic [VEC_W-1:0]          src_vector,
  input  logic [ERR_W-1:0]          src_code,
  input  fault_esc_pkg::exc_class_t cls,
  input  logic                      pushes_code,
  input  logic                      code_is_zero,
  input  logic                      reserved,
  input  logic                      dlv_done,
  output logic                      issue,
  output logic [VEC_W-1:0]          issue_vector,
  output logic                      issue_has_code,
  output logic [ERR_W-1:0]          issue_code,
  output fault_esc_pkg::exc_class_t st_q,
  output logic                      shut_q
);
  import fault_esc_pkg::*;

  logic       accept;
  logic       severe;
  logic       escalate;
  logic       kill;
  exc_class_t st_d;

  assign accept   = src_valid && !reserved && !shut_q;
  assign severe   = (cls == CLS_CONTRIB) || (cls == CLS_PAGE);
  assign escalate = ((cls == CLS_CONTRIB) && (st_q == CLS_CONTRIB || st_q == CLS_PAGE)) ||
                    ((cls == CLS_PAGE) && (st_q == CLS_PAGE));
  assign kill     = severe && (st_q == CLS_DOUBLE);
  assign issue    = accept && !kill;

  always_comb begin
    issue_vector   = src_vector;
    issue_has_code = pushes_code;
    issue_code     = (pushes_code && !code_is_zero) ? src_code : '0;
    if (escalate) begin
      issue_vector   = VEC_W'(VEC_DOUBLE);
      issue_has_code = 1'b1;
      issue_code     = '0;
    end
  end

  always_comb begin
    st_d = st_q;
    if (issue)          st_d = escalate ? CLS_DOUBLE : cls;
    else if (!accept && dlv_done) st_d = CLS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CLS_IDLE;
      shut_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      shut_q <= shut_q || (accept && kill);
    end
  end

  // R5: once set, shutdown is held
  a_r5_shut_sticky: assert property (@(posedge clk) disable iff (rst)
    shut_q |=> shut_q);

  // R10: a reserved vector leaves the tracked class untouched
  a_r10_reserved_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (src_valid && reserved && !dlv_done) |=> $stable(st_q));

endmodule

// File: rtl/fault_esc_outreg.sv
module fault_esc_outreg #(
  parameter int VEC_W = 8,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [VEC_W-1:0] issue_vector,
  input  logic             issue_has_code,
  input  logic [ERR_W-1:0] issue_code,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vector,
  output logic             out_has_code,
  output logic [ERR_W-1:0] out_code
);

  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      out_valid    <= 1'b0;
      out_vector   <= '0;
      out_has_code <= 1'b0;
      out_code     <= '0;
    end else begin
      out_valid    <= 1'b1;
      out_vector   <= issue_vector;
      out_has_code <= issue_has_code;
      out_code     <= issue_code;
    end
  end

  // R2: no code value without the code flag
  a_r2_code_needs_flag: assert property (@(posedge clk) disable iff (rst)
    !out_has_code |-> (out_code == '0));

endmodule

// File: rtl/fault_escalator.sv
module fault_escalator #(
  parameter int VEC_W    = 8,
  parameter int ERR_W    = 16,
  parameter int IRQ_BASE = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_valid,
  input  logic [VEC_W-1:0] exc_vector,
  input  logic [ERR_W-1:0] exc_code,
  input  logic             dlv_done,
  input  logic             task_sw,
  input  logic             fpu_op,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vector,
  output logic             out_has_code,
  output logic [ERR_W-1:0] out_code,
  output logic             shutdown
);
  import fault_esc_pkg::*;

  logic             src_valid;
  logic [VEC_W-1:0] src_vector;
  logic [ERR_W-1:0] src_code;
  exc_class_t       cls_w;
  logic             pushes_w;
  logic             zero_w;
  logic             rsv_w;
  logic             issue_w;
  logic [VEC_W-1:0] iss_vec_w;
  logic             iss_has_w;
  logic [ERR_W-1:0] iss_code_w;
  exc_class_t       st_w;

  fault_esc_src #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_src (
    .exc_valid (exc_valid), .exc_vector(exc_vector), .exc_code(exc_code),
    .task_sw   (task_sw),   .fpu_op    (fpu_op),
    .src_valid (src_valid), .src_vector(src_vector), .src_code(src_code)
  );

  fault_esc_classify #(.VEC_W(VEC_W), .IRQ_BASE(IRQ_BASE)) u_cls (
    .vec_in      (src_valid), .vector(src_vector), .cls(cls_w),
    .pushes_code (pushes_w),  .code_is_zero(zero_w), .reserved(rsv_w)
  );

  fault_esc_track #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_trk (
    .clk (clk), .rst(rst),
    .src_valid(src_valid), .src_vector(src_vector), .src_code(src_code),
    .cls(cls_w), .pushes_code(pushes_w), .code_is_zero(zero_w), .reserved(rsv_w),
    .dlv_done(dlv_done),
    .issue(issue_w), .issue_vector(iss_vec_w), .issue_has_code(iss_has_w),
    .issue_code(iss_code_w), .st_q(st_w), .shut_q(shutdown)
  );

  fault_esc_outreg #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_out (
    .clk(clk), .rst(rst),
    .issue(issue_w), .issue_vector(iss_vec_w), .issue_has_code(iss_has_w),
    .issue_code(iss_code_w),
    .out_valid(out_valid), .out_vector(out_vector),
    .out_has_code(out_has_code), .out_code(out_code)
  );

  // R3: contributory on top of contributory becomes a double fault
  a_r3_contrib_pair: assert property (@(posedge clk) disable iff (rst)
    (src_valid && cls_w == CLS_CONTRIB && st_w == CLS_CONTRIB && !shutdown)
    |=> (out_valid && out_vector == VEC_W'(VEC_DOUBLE) && out_has_code && out_code == '0));

  // R5: no result issued while shut down
  a_r5_silent_when_shut: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> !out_valid);

  // R7: external interrupt vectors never carry a code
  a_r7_irq_no_code: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'(out_vector) >= IRQ_BASE) |-> !out_has_code);

  // R10: reserved vectors produce no result
  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && rsv_w) |=> !out_valid);

endmodule

// File: tb/test_fault_escalator.sv
`timescale 1ns/1ps
module test_fault_escalator;

  logic        clk = 1'b0;
  logic        rst;
  logic        exc_valid;
  logic [7:0]  exc_vector;
  logic [15:0] exc_code;
  logic        dlv_done;
  logic        task_sw;
  logic        fpu_op;
  logic        out_valid;
  logic [7:0]  out_vector;
  logic        out_has_code;
  logic [15:0] out_code;
  logic        shutdown;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fault_escalator i_fault_escalator (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_vector(exc_vector),
    .exc_code(exc_code), .dlv_done(dlv_done), .task_sw(task_sw), .fpu_op(fpu_op),
    .out_valid(out_valid), .out_vector(out_vector), .out_has_code(out_has_code),
    .out_code(out_code), .shutdown(shutdown)
  );

  // row layout: [54] valid [53:46] vec [45:30] code [29] done [28] ts [27] fpu
  //             [26] exp valid [25:18] exp vec [17] exp has [16:1] exp code [0] exp shut
  function automatic logic [54:0] row(bit v, bit [7:0] vec, bit [15:0] c, bit d, bit t,
                                      bit f, bit xv, bit [7:0] xvec, bit xh,
                                      bit [15:0] xc, bit xs);
    return {v, vec, c, d, t, f, xv, xvec, xh, xc, xs};
  endfunction

  localparam int NROW = 26;
  localparam logic [54:0] TBL [NROW] = '{
    row(1, 8'h00, 16'h0000, 0, 0, 0, 1, 8'h00, 0, 16'h0000, 0), // R1 contributory from idle
    row(0, 8'h00, 16'h0000, 1, 0, 0, 0, 8'h00, 0, 16'h0000, 0), // R9 done
    row(1, 8'h0D, 16'h1234, 0, 0, 0, 1, 8'h0D, 1, 16'h1234, 0), // R2 code passed
    row(1, 8'h0C, 16'h0055, 0, 0, 0, 1, 8'h08, 1, 16'h0000, 0), // R3 escalate
    row(1, 8'h03, 16'h0000, 0, 0, 0, 1, 8'h03, 0, 16'h0000, 0), // R6 benign in double
    row(1, 8'h0E, 16'h0006, 0, 0, 0, 1, 8'h0E, 1, 16'h0006, 0), // R2 page fault
    row(1, 8'h0E, 16'h0007, 0, 0, 0, 1, 8'h08, 1, 16'h0000, 0), // R4 pf on pf
    row(0, 8'h00, 16'h0000, 1, 0, 0, 0, 8'h00, 0, 16'h0000, 0), // R9 done
    row(1, 8'h11, 16'hBEEF, 0, 0, 0, 1, 8'h11, 1, 16'h0000, 0), // R2 alignment zero code
    row(1, 8'h21, 16'hAAAA, 0, 0, 0, 1, 8'h21, 0, 16'h0000, 0), // R7 interrupt
    row(1, 8'h0A, 16'h0102, 0, 0, 0, 1, 8'h0A, 1, 16'h0102, 0), // R2 code passed
    row(1, 8'h0F, 16'h0000, 0, 0, 0, 0, 8'h00, 0, 16'h0000, 0), // R10 reserved
    row(1, 8'h0B, 16'h0B0B, 0, 0, 0, 1, 8'h08, 1, 16'h0000, 0), // R10 state kept, R3
    row(0, 8'h00, 16'h0000, 1, 0, 0, 0, 8'h00, 0, 16'h0000, 0), // R9 done
    row(0, 8'h00, 16'h0000, 0, 1, 1, 1, 8'h07, 0, 16'h0000, 0), // R8 trap
    row(0, 8'h00, 16'h0000, 0, 0, 1, 0, 8'h00, 0, 16'h0000, 0), // R8 no trap
    row(1, 8'h01, 16'h0000, 0, 1, 1, 1, 8'h01, 0, 16'h0000, 0), // R8 explicit wins
    row(1, 8'h0E, 16'h0010, 0, 0, 0, 1, 8'h0E, 1, 16'h0010, 0), // R6 pf after benign
    row(1, 8'h02, 16'h0000, 0, 0, 0, 1, 8'h02, 0, 16'h0000, 0), // R6 benign in pf
    row(1, 8'h09, 16'h9999, 0, 0, 0, 1, 8'h09, 0, 16'h0000, 0), // R2 no code for 09h
    row(1, 8'h0E, 16'h0020, 0, 0, 0, 1, 8'h0E, 1, 16'h0020, 0), // R6 pf in contributory
    row(1, 8'h00, 16'h0000, 0, 0, 0, 1, 8'h08, 1, 16'h0000, 0), // R4 contrib in pf
    row(1, 8'h13, 16'h0000, 0, 0, 0, 0, 8'h00, 0, 16'h0000, 0), // R10 reserved
    row(1, 8'h0D, 16'h0005, 0, 0, 0, 0, 8'h00, 0, 16'h0000, 1), // R5 shutdown
    row(1, 8'h05, 16'h0000, 0, 0, 0, 0, 8'h00, 0, 16'h0000, 1), // R5 held
    row(0, 8'h00, 16'h0000, 0, 1, 1, 0, 8'h00, 0, 16'h0000, 1)  // R5 held
  };

  task automatic drive(bit v, bit [7:0] vec, bit [15:0] c, bit d, bit t, bit f);
    exc_valid = v; exc_vector = vec; exc_code = c; dlv_done = d; task_sw = t; fpu_op = f;
  endtask

  task automatic expect_out(string req, bit xv, bit [7:0] xvec, bit xh, bit [15:0] xc,
                            bit xs);
    logic [26:0] act, exp;
    act = {out_valid, out_vector, out_has_code, out_code, shutdown};
    exp = {xv, xvec, xh, xc, xs};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual v=%b vec=%h has=%b code=%h shut=%b expected v=%b vec=%h has=%b code=%h shut=%b",
               req, act[26], act[25:18], act[17], act[16:1], act[0],
               xv, xvec, xh, xc, xs);
    end
  endtask

  task automatic step(string req, bit v, bit [7:0] vec, bit [15:0] c, bit d, bit t, bit f,
                      bit xv, bit [7:0] xvec, bit xh, bit [15:0] xc, bit xs);
    drive(v, vec, c, d, t, f);
    @(negedge clk);
    expect_out(req, xv, xvec, xh, xc, xs);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(0, 8'h00, 16'h0000, 0, 0, 0);
    repeat (2) @(negedge clk);
    expect_out("R11", 0, 8'h00, 0, 16'h0000, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NROW; i++) begin
      logic [54:0] r;
      r = TBL[i];
      step($sformatf("row %0d", i), r[54], r[53:46], r[45:30], r[29], r[28], r[27],
           r[26], r[25:18], r[17], r[16:1], r[0]);
    end
    // R11: reset clears a latched shutdown
    do_reset();
    // R12: vector 08h raised directly, then contributory -> shutdown
    step("R12", 1, 8'h08, 16'h7777, 0, 0, 0, 1, 8'h08, 1, 16'h0000, 0);
    step("R12", 1, 8'h0C, 16'h0001, 0, 0, 0, 0, 8'h00, 0, 16'h0000, 1);
    do_reset();
    // R9: done in the same cycle as an accepted event is ignored
    step("R1", 1, 8'h00, 16'h0000, 0, 0, 0, 1, 8'h00, 0, 16'h0000, 0);
    step("R9", 1, 8'h0D, 16'h0003, 1, 0, 0, 1, 8'h08, 1, 16'h0000, 0);
    // R7: interrupt during double fault delivered, no shutdown
    step("R7", 1, 8'hFF, 16'h4444, 0, 0, 0, 1, 8'hFF, 0, 16'h0000, 0);
    step("R9", 0, 8'h00, 16'h0000, 1, 0, 0, 0, 8'h00, 0, 16'h0000, 0);
    step("R9", 1, 8'h0C, 16'h0001, 0, 0, 0, 1, 8'h0C, 1, 16'h0001, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule